// File: doc/BRIEF.md
# Host Register Block with Per-Field Access Modes

This block gives a host processor a small 32-bit register space. The host uses a plain bus with an address, a chip select, a read-not-write flag, write data and read data. Two registers are decoded. The first is an identification register. It is read-only and holds a fixed two-byte code. The second is a control register. Its bits each have their own access mode and drive user logic or are fed by it.

The control register holds three fields. A persistent read-write bit drives a module-reset output to user logic. A write-only start bit self-clears and gives a single-cycle pulse. A read-only status bit reflects a user-logic input. The control register has a reset value, so each of its flops is cleared or set by the asynchronous reset. A write to the identification register leaves its contents unchanged, but it raises a one-cycle strobe toward user logic.

Top module: `mm_field_regs`

## Requirements
- R1: While `rst` is high and after it falls, with no access made, the outputs hold these values: `rdata` 0, `mod_rst_o` 1, `start_o` 0 and `id_wstb_o` 0.
- R2: A read of offset 0x000 returns 0x00000100 on `rdata`, valid one clock after the access. The major byte is in bits 15:8 and the minor byte is in bits 7:0.
- R3: A write to offset 0x000 does not change what that register reads back. It pulses `id_wstb_o` high for exactly the one clock after the write edge.
- R4: Bit 31 of the control register at offset 0x100 is read-write. A write loads it, `mod_rst_o` follows from the write edge, and reads return it in bit 31. No other access changes it.
- R5: Writing 1 to bit 0 of offset 0x100 drives `start_o` high for the one clock after the write edge, and the bit then clears. Writing 0 gives no pulse. Bit 0 always reads as 0.
- R6: Bit 1 of offset 0x100 reads the current value of `done_i`. Writes to that bit are ignored.
- R7: Reads of unmapped addresses and of unused bits return 0. Writes to unmapped addresses change no register and no output.
- R8: Nothing happens while `cs` is low. `rdata` keeps its last value and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| addr | input | 32 | Byte address of the access |
| cs | input | 1 | Chip select; an access occurs only while it is high |
| rnw | input | 1 | 1 = read, 0 = write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| done_i | input | 1 | Status from user logic, read at control bit 1 |
| mod_rst_o | output | 1 | Module-reset field, control bit 31 |
| start_o | output | 1 | Self-clearing start pulse, control bit 0 |
| id_wstb_o | output | 1 | One-cycle strobe on a write to the identification register |

## Verification
The assertions take for granted that `rst` is asserted from time zero. They also assume that `cs`, `rnw`, `addr` and `wdata` are stable around each rising edge. The pulse checks tie each pulse to the access in the previous cycle, so back-to-back writes are allowed. The stimulus changes every input only on falling edges, and it holds `rst` high for several edges before the first access. Each access keeps `cs` high for exactly one rising edge.

// File: rtl/mm_field_regs.sv
module mm_field_regs #(
  parameter int          DW       = 32,
  parameter int          AW       = 32,
  parameter logic [AW-1:0] ID_ADDR  = 'h000,
  parameter logic [AW-1:0] CTL_ADDR = 'h100,
  parameter logic [7:0]  ID_MAJOR = 8'h01,
  parameter logic [7:0]  ID_MINOR = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          cs,
  input  logic          rnw,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          done_i,
  output logic          mod_rst_o,
  output logic          start_o,
  output logic          id_wstb_o
);
  localparam int MRST_BIT  = DW - 1;
  localparam int DONE_BIT  = 1;
  localparam int START_BIT = 0;

  logic          hit_id, hit_ctl, wr, rd;
  logic [7:0]    id_major_q, id_minor_q;
  logic [DW-1:0] rd_mux;

  assign hit_id  = (addr == ID_ADDR);
  assign hit_ctl = (addr == CTL_ADDR);
  assign wr      = cs && !rnw;
  assign rd      = cs && rnw;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      id_major_q <= ID_MAJOR;
      id_minor_q <= ID_MINOR;
    end else begin
      id_major_q <= id_major_q;
      id_minor_q <= id_minor_q;
    end

  always_ff @(posedge clk or posedge rst)
    if (rst) id_wstb_o <= 1'b0;
    else     id_wstb_o <= wr && hit_id;

  always_ff @(posedge clk or posedge rst)
    if (rst)                mod_rst_o <= 1'b1;
    else if (wr && hit_ctl) mod_rst_o <= wdata[MRST_BIT];

  always_ff @(posedge clk or posedge rst)
    if (rst) start_o <= 1'b0;
    else     start_o <= wr && hit_ctl && wdata[START_BIT];

  always_comb begin
    rd_mux = '0;
    if (hit_id) begin
      rd_mux[15:8] = id_major_q;
      rd_mux[7:0]  = id_minor_q;
    end
    if (hit_ctl) begin
      rd_mux[MRST_BIT] = mod_rst_o;
      rd_mux[DONE_BIT] = done_i;
    end
  end

  always_ff @(posedge clk or posedge rst)
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(cs && !rnw && addr == CTL_ADDR && wdata[START_BIT])); // R5
  AST_STB_CAUSE: assert property (@(posedge clk) disable iff (rst)
    id_wstb_o |-> $past(cs && !rnw && addr == ID_ADDR)); // R3
  AST_MRST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(cs && !rnw && addr == CTL_ADDR) |-> $stable(mod_rst_o)); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(cs && rnw) |-> $stable(rdata)); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata[DW-2:16] == '0); // R7
  AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
    $past(cs && rnw && addr == ID_ADDR) |-> rdata[15:0] == {ID_MAJOR, ID_MINOR}); // R2
endmodule

// File: tb/mm_field_regs_tb.sv
module mm_field_regs_tb;
  logic        clk = 1'b0, rst = 1'b1, cs = 1'b0, rnw = 1'b1, done_i = 1'b0;
  logic [31:0] addr = '0, wdata = '0, rdata;
  logic        mod_rst_o, start_o, id_wstb_o;
  int          total = 0, bad = 0;
  logic        rd_seen = 1'b0, finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  mm_field_regs u_dut (.clk(clk), .rst(rst), .addr(addr), .cs(cs), .rnw(rnw),
    .wdata(wdata), .rdata(rdata), .done_i(done_i), .mod_rst_o(mod_rst_o),
    .start_o(start_o), .id_wstb_o(id_wstb_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [31:0] d, input logic r);
    @(negedge clk);
    cs = 1'b1; rnw = r; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; rnw = 1'b1;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    access(a, '0, 1'b1);
  endtask

  always @(posedge clk) rd_seen <= cs && rnw && !rst;

  always @(negedge clk)
    if (rd_seen) begin
      if (exp_q.size() == 0) check("read without expectation", rdata, 'x);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata reset", rdata, 0);
    check("R1 mod_rst reset", {31'd0, mod_rst_o}, 1);
    check("R1 start reset", {31'd0, start_o}, 0);
    check("R1 strobe reset", {31'd0, id_wstb_o}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 outputs idle after reset", {29'd0, mod_rst_o, start_o, id_wstb_o}, 32'h4);

    rd(32'h000, 32'h0000_0100, "R2 id read");
    access(32'h000, 32'hFFFF_FFFF, 1'b0);
    check("R3 strobe high", {31'd0, id_wstb_o}, 1);
    @(negedge clk);
    check("R3 strobe one cycle", {31'd0, id_wstb_o}, 0);
    rd(32'h000, 32'h0000_0100, "R3 id unchanged");

    rd(32'h100, 32'h8000_0000, "R4 ctl reset value");
    done_i = 1'b1;
    rd(32'h100, 32'h8000_0002, "R6 done reads 1");
    done_i = 1'b0;
    access(32'h100, 32'h0000_0000, 1'b0);
    check("R4 mod_rst cleared", {31'd0, mod_rst_o}, 0);
    check("R5 no pulse on 0", {31'd0, start_o}, 0);
    rd(32'h100, 32'h0000_0000, "R4 ctl readback 0");

    access(32'h100, 32'h8000_0001, 1'b0);
    check("R5 start pulse", {31'd0, start_o}, 1);
    check("R4 mod_rst set", {31'd0, mod_rst_o}, 1);
    @(negedge clk);
    check("R5 start self-clears", {31'd0, start_o}, 0);
    rd(32'h100, 32'h8000_0000, "R5 start reads 0");

    access(32'h100, 32'h8000_0002, 1'b0);
    rd(32'h100, 32'h8000_0000, "R6 done write ignored");

    rd(32'h104, 32'h0, "R7 unmapped read");
    access(32'h200, 32'h0000_0000, 1'b0);
    check("R7 unmapped write no strobe", {31'd0, id_wstb_o}, 0);
    check("R7 unmapped write no start", {31'd0, start_o}, 0);
    rd(32'h100, 32'h8000_0000, "R7 ctl after unmapped write");

    @(negedge clk);
    cs = 1'b0; rnw = 1'b0; addr = 32'h100; wdata = 32'h0000_0001;
    @(negedge clk);
    check("R8 no write without cs", {30'd0, mod_rst_o, start_o}, 32'h2);
    rnw = 1'b1; addr = 32'h000;
    @(negedge clk);
    check("R8 rdata holds without cs", rdata, 32'h8000_0000);

    repeat (2) @(negedge clk);
    check("read queue drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule